// File: doc/BRIEF.md
# Flyback Gate On-Time Supervisor

This block controls the length of each switching pulse in a quasi-resonant flyback controller. The valley-detection logic issues a turn-on request. The block then raises a registered gate-enable output and holds it high until a cut-off condition ends the pulse. There are three such conditions: the overcurrent comparator once the leading-edge blanking window has passed, a hard maximum on-time, or a detected sense fault. Each gate-off event is reported as a one-cycle strobe together with a registered cause code.

The block also watches a second comparator, which reports that the sensed current is abnormally small. It samples that comparator once per pulse, at a fixed delay after turn-on. It counts how many pulses in a row showed a low sample. When the count reaches three, it latches an auto-restart fault. The fault holds the gate off and blocks new turn-on requests until a synchronous clear input is pulsed. The blanking time, the maximum on-time and the sample delay are parameters counted in clock cycles.

Top module: `gate_ontime_sup`

## Requirements
- R1: Synchronous active-high reset drives gate_en, restart_fault and off_event low, sets off_reason to 0, and empties the low-sample run counter.
- R2: When turn_on_req is high at a clock edge while gate_en is low and restart_fault is low, gate_en is high from that edge on.
- R3: After turn-on, oc_trip is ignored for the first BLANK_CYC high cycles, so every pulse stays high at least BLANK_CYC cycles.
- R4: After blanking, oc_trip high at an edge drives gate_en low at that edge with off_reason = 1. With oc_trip held high from its k-th high cycle, the pulse lasts max(k, BLANK_CYC) cycles.
- R5: A pulse that no other condition ends lasts exactly MAX_ON_CYC cycles and ends with off_reason = 2.
- R6: cs_low is sampled in the SAMPLE_CYC-th high cycle of each pulse. The third consecutive low sample sets restart_fault and ends the pulse at that edge with off_reason = 3.
- R7: A pulse whose sample sees cs_low = 0 resets the run of low samples to zero. A pulse that ends before its sample cycle leaves the run unchanged.
- R8: While restart_fault is high, gate_en stays low and turn-on requests are ignored. A fault_clr pulse clears both the fault and the run of low samples.
- R9: A turn-on request that arrives while gate_en is high neither restarts nor extends the current pulse.
- R10: off_event is high for exactly the first low cycle after each pulse. off_reason holds its value until the next gate-off event.
- R11: When several causes fall on the same edge, overcurrent (1) wins over maximum on-time (2), and maximum on-time wins over fault (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| turn_on_req | input | 1 | Pulse start request from valley detection |
| oc_trip | input | 1 | Overcurrent comparator output |
| cs_low | input | 1 | Sense-too-low comparator output |
| fault_clr | input | 1 | Synchronous clear of the auto-restart fault |
| gate_en | output | 1 | Registered gate enable |
| restart_fault | output | 1 | Latched auto-restart fault |
| off_event | output | 1 | One-cycle strobe after each gate-off |
| off_reason | output | 2 | Cause of the last gate-off: 0 none, 1 overcurrent, 2 max on-time, 3 fault |

## Verification
A wrong on-time count shows up at the port as a pulse length that differs from the expected length. It becomes visible at the end of the affected pulse, which is at most MAX_ON_CYC cycles after turn-on. A wrong run counter cannot be seen until a later pulse: the fault appears one pulse too early or too late, or an interrupted pulse wrongly clears the run. The bench therefore walks sequences of several pulses and checks restart_fault and off_reason after each one. A cause-priority error shows up in off_reason on the single edge where two causes coincide.

// File: rtl/gos_pkg.sv
package gos_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_OC    = 2'd1,
    CAUSE_MAXON = 2'd2,
    CAUSE_FAULT = 2'd3
  } off_cause_e;
endpackage

// File: rtl/gos_ontime_timer.sv
module gos_ontime_timer #(
  parameter int BLANK_CYC  = 4,
  parameter int MAX_ON_CYC = 40,
  parameter int SAMPLE_CYC = 10,
  localparam int CW = $clog2(MAX_ON_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic gate_on,
  output logic blank_done,
  output logic max_hit,
  output logic sample_now
);
  logic [CW-1:0] cnt_q;

  // cnt_q holds the number of completed high cycles; 0 in the first one
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (gate_on && cnt_q != CW'(MAX_ON_CYC - 1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    blank_done = gate_on && (cnt_q >= CW'(BLANK_CYC - 1));
    max_hit    = gate_on && (cnt_q == CW'(MAX_ON_CYC - 1));
    sample_now = gate_on && (cnt_q == CW'(SAMPLE_CYC - 1));
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    gate_on |-> (cnt_q <= CW'(MAX_ON_CYC - 1)));
endmodule

// File: rtl/gos_lowsense_tracker.sv
module gos_lowsense_tracker #(
  parameter int LOW_PULSES = 3,
  localparam int RW = $clog2(LOW_PULSES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_now,
  input  logic cs_low,
  input  logic clr,
  output logic trip,
  output logic fault_q
);
  logic [RW-1:0] run_q;

  assign trip = sample_now && cs_low && !clr && (run_q == RW'(LOW_PULSES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      fault_q <= 1'b0;
    end else if (clr) begin
      run_q   <= '0;
      fault_q <= 1'b0;
    end else if (sample_now) begin
      if (!cs_low) begin
        run_q <= '0;
      end else if (trip) begin
        run_q   <= '0;
        fault_q <= 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assert_fault_from_sample_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_q) |-> $past(sample_now && cs_low));
  assert_run_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!sample_now && !clr) |=> $stable(run_q));
  assert_run_bound_R6: assert property (@(posedge clk) disable iff (rst)
    run_q < RW'(LOW_PULSES));
  assert_clr_effect_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!fault_q && run_q == '0));
endmodule

// File: rtl/gos_gate_ctrl.sv
module gos_gate_ctrl
  import gos_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       oc,
  input  logic       fault_q,
  input  logic       blank_done,
  input  logic       max_hit,
  input  logic       trip,
  output logic       start,
  output logic       gate_q,
  output logic       event_q,
  output off_cause_e reason_q
);
  logic       oc_cut;
  logic       stop;
  off_cause_e cause;

  always_comb begin
    oc_cut = blank_done && oc;
    stop   = gate_q && (oc_cut || max_hit || trip);
    start  = req && !gate_q && !fault_q;
    if (oc_cut)       cause = CAUSE_OC;
    else if (max_hit) cause = CAUSE_MAXON;
    else if (trip)    cause = CAUSE_FAULT;
    else              cause = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q   <= 1'b0;
      event_q  <= 1'b0;
      reason_q <= CAUSE_NONE;
    end else begin
      event_q <= stop;
      if (stop) begin
        gate_q   <= 1'b0;
        reason_q <= cause;
      end else if (start) begin
        gate_q <= 1'b1;
      end
    end
  end

  assert_min_on_R3: assert property (@(posedge clk) disable iff (rst)
    (gate_q && !blank_done) |=> gate_q);
  assert_max_cut_R5: assert property (@(posedge clk) disable iff (rst)
    max_hit |=> !gate_q);
  assert_rise_needs_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> $past(!fault_q && req));
endmodule

// File: rtl/gate_ontime_sup.sv
module gate_ontime_sup #(
  parameter int BLANK_CYC  = 4,
  parameter int MAX_ON_CYC = 40,
  parameter int SAMPLE_CYC = 10,
  parameter int LOW_PULSES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       turn_on_req,
  input  logic       oc_trip,
  input  logic       cs_low,
  input  logic       fault_clr,
  output logic       gate_en,
  output logic       restart_fault,
  output logic       off_event,
  output logic [1:0] off_reason
);
  import gos_pkg::*;

  initial begin
    if (BLANK_CYC < 1 || SAMPLE_CYC < BLANK_CYC || MAX_ON_CYC < SAMPLE_CYC || LOW_PULSES < 1)
      $fatal(1, "gate_ontime_sup: need 1 <= BLANK_CYC <= SAMPLE_CYC <= MAX_ON_CYC");
  end

  logic       start, blank_done, max_hit, sample_now, trip;
  off_cause_e reason;

  gos_ontime_timer #(
    .BLANK_CYC (BLANK_CYC),
    .MAX_ON_CYC(MAX_ON_CYC),
    .SAMPLE_CYC(SAMPLE_CYC)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .gate_on   (gate_en),
    .blank_done(blank_done),
    .max_hit   (max_hit),
    .sample_now(sample_now)
  );

  gos_lowsense_tracker #(
    .LOW_PULSES(LOW_PULSES)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .sample_now(sample_now),
    .cs_low    (cs_low),
    .clr       (fault_clr),
    .trip      (trip),
    .fault_q   (restart_fault)
  );

  gos_gate_ctrl u_gate (
    .clk       (clk),
    .rst       (rst),
    .req       (turn_on_req),
    .oc        (oc_trip),
    .fault_q   (restart_fault),
    .blank_done(blank_done),
    .max_hit   (max_hit),
    .trip      (trip),
    .start     (start),
    .gate_q    (gate_en),
    .event_q   (off_event),
    .reason_q  (reason)
  );

  assign off_reason = reason;

  assert_fault_gate_low_R8: assert property (@(posedge clk) disable iff (rst)
    restart_fault |-> !gate_en);
  assert_event_single_R10: assert property (@(posedge clk) disable iff (rst)
    off_event |=> !off_event);
  assert_event_after_fall_R10: assert property (@(posedge clk) disable iff (rst)
    off_event |-> (!gate_en && $past(gate_en)));
endmodule

// File: tb/gate_ontime_sup_test.sv
`timescale 1ns/1ps
module gate_ontime_sup_test;
  localparam int BLANK = 4;
  localparam int MAXON = 40;
  localparam int SAMP  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic turn_on_req = 1'b0, oc_trip = 1'b0, cs_low = 1'b0, fault_clr = 1'b0;
  logic gate_en, restart_fault, off_event;
  logic [1:0] off_reason;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gate_ontime_sup #(.BLANK_CYC(BLANK), .MAX_ON_CYC(MAXON), .SAMPLE_CYC(SAMP), .LOW_PULSES(3)) uut (
    .clk(clk), .rst(rst), .turn_on_req(turn_on_req), .oc_trip(oc_trip), .cs_low(cs_low),
    .fault_clr(fault_clr), .gate_en(gate_en), .restart_fault(restart_fault),
    .off_event(off_event), .off_reason(off_reason));

  typedef struct packed {
    int       oc_from;   // first high cycle with oc_trip set, 0 = never
    logic     cs;
    int       len;
    logic [1:0] rsn;
    logic     flt;
  } vec_t;

  // run of low samples noted per row
  localparam vec_t VECS [9] = '{
    '{0,  1'b0, 40, 2'd2, 1'b0},  // R5 max cut, run 0
    '{1,  1'b0, 4,  2'd1, 1'b0},  // R3 blanking enforces min on
    '{20, 1'b1, 20, 2'd1, 1'b0},  // R4 run 1
    '{2,  1'b1, 4,  2'd1, 1'b0},  // R7 ends before sample, run stays 1
    '{0,  1'b1, 40, 2'd2, 1'b0},  // run 2
    '{0,  1'b0, 40, 2'd2, 1'b0},  // R7 high sample resets run
    '{15, 1'b1, 15, 2'd1, 1'b0},  // run 1
    '{12, 1'b1, 12, 2'd1, 1'b0},  // run 2
    '{10, 1'b1, 10, 2'd1, 1'b1}   // R11 oc wins over fault, R6 fault set
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int oc_from, input logic cs, input int rereq_at,
                       input int exp_len, input int exp_rsn, input int exp_flt,
                       input string tag);
    int len = 0;
    @(negedge clk) turn_on_req = 1'b1;
    @(negedge clk) turn_on_req = 1'b0;
    while (gate_en && len < MAXON + 5) begin
      len++;
      oc_trip     = (oc_from != 0) && (len >= oc_from);
      cs_low      = cs;
      turn_on_req = (len == rereq_at);
      @(negedge clk);
    end
    oc_trip = 1'b0; cs_low = 1'b0; turn_on_req = 1'b0;
    check({tag, " length"}, len, exp_len);
    check({tag, " R10 off_event"}, int'(off_event), 1);
    check({tag, " off_reason"}, int'(off_reason), exp_rsn);
    check({tag, " restart_fault"}, int'(restart_fault), exp_flt);
    @(negedge clk);
    check({tag, " R10 strobe one cycle"}, int'(off_event), 0);
    check({tag, " R10 reason held"}, int'(off_reason), exp_rsn);
  endtask

  task automatic clear_fault();
    @(negedge clk) fault_clr = 1'b1;
    @(negedge clk) fault_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 gate after reset", int'(gate_en), 0);
    check("R1 fault after reset", int'(restart_fault), 0);
    check("R1 event after reset", int'(off_event), 0);
    check("R1 reason after reset", int'(off_reason), 0);
    rst = 1'b0;

    // R2: gate rises at the edge that sees the request
    @(negedge clk) turn_on_req = 1'b1;
    @(negedge clk) turn_on_req = 1'b0;
    check("R2 gate rises", int'(gate_en), 1);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R1 reset mid-pulse", int'(gate_en), 0);

    foreach (VECS[i])
      pulse(VECS[i].oc_from, VECS[i].cs, -1, VECS[i].len, int'(VECS[i].rsn),
            int'(VECS[i].flt), $sformatf("R4 vec %0d", i));

    // R8: requests ignored while faulted
    @(negedge clk) turn_on_req = 1'b1;
    repeat (3) @(negedge clk);
    turn_on_req = 1'b0;
    check("R8 gate held low in fault", int'(gate_en), 0);
    check("R8 fault latched", int'(restart_fault), 1);
    clear_fault();
    check("R8 clear drops fault", int'(restart_fault), 0);

    // R6: three low samples with no overcurrent end at the sample cycle
    pulse(0, 1'b1, -1, MAXON, 2, 0, "R6 low 1");
    pulse(0, 1'b1, -1, MAXON, 2, 0, "R6 low 2");
    pulse(0, 1'b1, -1, SAMP, 3, 1, "R6 low 3");
    clear_fault();

    // R8: clear also empties the run
    pulse(0, 1'b1, -1, MAXON, 2, 0, "R8 run a");
    pulse(0, 1'b1, -1, MAXON, 2, 0, "R8 run b");
    clear_fault();
    pulse(0, 1'b1, -1, MAXON, 2, 0, "R8 after clr 1");
    pulse(0, 1'b1, -1, MAXON, 2, 0, "R8 after clr 2");
    pulse(0, 1'b0, -1, MAXON, 2, 0, "R7 reset run");

    // R9: request during a pulse does not extend it
    pulse(0, 1'b0, 20, MAXON, 2, 0, "R9 re-request");
    pulse(6, 1'b0, 3, 6, 1, 0, "R9 re-request in blank");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule